// File: doc/BRIEF.md
# Parallel Printer Port Register Bank

This block is the processor-side register set of a byte-wide parallel printer port that sits in the I/O space of a CPU with a 16-bit data bus. It occupies three even I/O addresses: 38h holds the character byte to be driven onto the printer data lines, 3Ah returns a status byte built from the printer's status wires, and 3Ch holds the control byte that drives the printer's control wires. Only data lines 7..0 of the CPU bus carry information. The upper byte is discarded on writes and is returned as zero on reads.

A write happens on the clock edge at which the active-low write strobe is low and the address matches the data or control register. A read is combinational while the active-low read strobe is low and the address matches one of the three registers. The output enable for the CPU data bus is raised only then, so the bus is left free at every other time. Reading back the data and control registers lets software verify what it wrote. The status byte reflects the live printer lines.

Top module: `prt_regbank`

## Requirements
- R1: After reset the data register is 00h and the control outputs are strobe_n=1, autofd_n=1, init_n=1, selin_n=1, irq_en=0 and bidir=0, which is control byte 0Fh.
- R2: A clock edge with wr_n=0 and io_addr=38h loads din[7:0] into the data register, and the value appears on prn_data after that edge. din[15:8] has no effect.
- R3: A clock edge with wr_n=0 and io_addr=3Ch loads the control byte from din[5:0]. Bit0 is strobe_n, bit1 autofd_n, bit2 init_n, bit3 selin_n, bit4 irq_en and bit5 bidir. din[7:6] and din[15:8] are discarded.
- R4: With rd_n=0 and io_addr=3Ah, dout is {8'h00, busy, ack_n, paper_out_n, selected, fault_n, 3'b000}, with busy in bit7 and fault_n in bit3, taken from the current status inputs.
- R5: With rd_n=0, address 38h returns {8'h00, data register}, and address 3Ch returns {8'h00, 2'b00, control[5:0]}.
- R6: dout_oe is 1 only while rd_n=0 and io_addr is 38h, 3Ah or 3Ch. At all other times dout_oe is 0 and dout is 0000h. Odd neighbours such as 3Bh are not decoded.
- R7: A write to any address other than 38h and 3Ch, including 3Ah, 39h and 3Dh, changes neither register.
- R8: On clock edges with wr_n=1, both registers keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | CPU I/O address |
| wr_n | input | 1 | Active-low I/O write strobe |
| rd_n | input | 1 | Active-low I/O read strobe |
| din | input | 16 | CPU write data |
| dout | output | 16 | CPU read data, zero when not driving |
| dout_oe | output | 1 | Enable for the CPU data bus driver |
| busy | input | 1 | Printer busy status line |
| ack_n | input | 1 | Printer acknowledge status line, active low |
| paper_out_n | input | 1 | Paper-empty status line as seen at the port |
| selected | input | 1 | Printer selected status line |
| fault_n | input | 1 | Printer error status line, active low |
| prn_data | output | 8 | Character byte to the printer data lines |
| strobe_n | output | 1 | Data strobe control line |
| autofd_n | output | 1 | Automatic line-feed control line |
| init_n | output | 1 | Printer initialise control line |
| selin_n | output | 1 | Select-input control line |
| irq_en | output | 1 | Interrupt enable control bit |
| bidir | output | 1 | Bidirectional data-line mode bit |

## Verification
The hardest case to bring about is an access that is one address off from a register, such as a write to 39h, 3Bh or 3Dh, or a write to the read-only status address. A correct design ignores all of these, so their effect can only be seen by a later readback. The stimulus therefore follows each such write with a read of the register it might have disturbed, and it uses values that differ in every bit from the value already held. Status reads use two complementary line patterns, so that a swapped or stuck bit position changes the result.

// File: rtl/prt_pkg.sv
package prt_pkg;

    localparam int unsigned BUS_W   = 16;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned IOA_W   = 8;
    localparam int unsigned NSLOT   = 3;
    localparam int unsigned SLOT_DATA = 0;
    localparam int unsigned SLOT_STAT = 1;
    localparam int unsigned SLOT_CTRL = 2;
    localparam int unsigned CTL_W   = 6;
    localparam int unsigned STAT_W  = 5;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    // Field order fixes the bit positions: strobe_n is bit0, bidir is bit5.
    typedef struct packed {
        logic bidir;
        logic irq_en;
        logic selin_n;
        logic init_n;
        logic autofd_n;
        logic strobe_n;
    } ctl_t;

    // busy lands in bit7 of the status byte, fault_n in bit3.
    typedef struct packed {
        logic busy;
        logic ack_n;
        logic paper_out_n;
        logic selected;
        logic fault_n;
    } stat_t;

    localparam ctl_t CTL_RESET = '{bidir: 1'b0, irq_en: 1'b0, selin_n: 1'b1,
                                   init_n: 1'b1, autofd_n: 1'b1, strobe_n: 1'b1};

    function automatic int unsigned slot_addr(int unsigned base, int unsigned step,
                                              int unsigned idx);
        return base + idx * step;
    endfunction

    function automatic logic [BYTE_W-1:0] stat_byte(stat_t s);
        return {s, {(BYTE_W-STAT_W){1'b0}}};
    endfunction

    function automatic logic [BYTE_W-1:0] ctl_byte(ctl_t c);
        return {{(BYTE_W-CTL_W){1'b0}}, c};
    endfunction

    function automatic sel_e slot_to_sel(logic [NSLOT-1:0] hit);
        sel_e s;
        s = SEL_NONE;
        if (hit[SLOT_DATA])      s = SEL_DATA;
        else if (hit[SLOT_STAT]) s = SEL_STAT;
        else if (hit[SLOT_CTRL]) s = SEL_CTRL;
        return s;
    endfunction

endpackage

// File: rtl/prt_decode.sv
module prt_decode
    import prt_pkg::*;
#(
    parameter int unsigned ADDR_W = IOA_W,
    parameter int unsigned BASE   = 32'h38,
    parameter int unsigned STEP   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    logic [NSLOT-1:0] hit;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        localparam int unsigned SLOT_A = slot_addr(BASE, STEP, i);
        assign hit[i] = (addr == ADDR_W'(SLOT_A));
    end

    always_comb sel = slot_to_sel(hit);

endmodule

// File: rtl/prt_wrregs.sv
module prt_wrregs
    import prt_pkg::*;
#(
    parameter int unsigned DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_act,
    input  sel_e          sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] data_q,
    output ctl_t          ctl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            ctl_q  <= CTL_RESET;
        end else if (wr_act) begin
            case (sel)
                SEL_DATA: data_q <= wdata;
                SEL_CTRL: ctl_q  <= ctl_t'(wdata[CTL_W-1:0]);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/prt_rdmux.sv
module prt_rdmux
    import prt_pkg::*;
#(
    parameter int unsigned BW = BUS_W,
    parameter int unsigned DW = BYTE_W
) (
    input  logic          rd_act,
    input  sel_e          sel,
    input  logic [DW-1:0] data_q,
    input  ctl_t          ctl_q,
    input  stat_t         stat,
    output logic [BW-1:0] rdata,
    output logic          drive
);
    localparam int unsigned PAD_W = BW - DW;
    logic [DW-1:0] rbyte;

    always_comb begin
        case (sel)
            SEL_DATA: rbyte = data_q;
            SEL_STAT: rbyte = stat_byte(stat);
            SEL_CTRL: rbyte = ctl_byte(ctl_q);
            default:  rbyte = '0;
        endcase
        drive = rd_act && (sel != SEL_NONE);
        rdata = drive ? {{PAD_W{1'b0}}, rbyte} : '0;
    end

endmodule

// File: rtl/prt_regbank.sv
module prt_regbank
    import prt_pkg::*;
#(
    parameter int unsigned ADDR_W = IOA_W,
    parameter int unsigned BW     = BUS_W,
    parameter int unsigned BASE   = 32'h38,
    parameter int unsigned STEP   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [BW-1:0]     din,
    output logic [BW-1:0]     dout,
    output logic              dout_oe,
    input  logic              busy,
    input  logic              ack_n,
    input  logic              paper_out_n,
    input  logic              selected,
    input  logic              fault_n,
    output logic [BYTE_W-1:0] prn_data,
    output logic              strobe_n,
    output logic              autofd_n,
    output logic              init_n,
    output logic              selin_n,
    output logic              irq_en,
    output logic              bidir
);
    sel_e  sel;
    ctl_t  ctl_q;
    stat_t stat;
    logic  unused_din_hi;

    assign unused_din_hi = ^din[BW-1:BYTE_W];
    assign stat = '{busy: busy, ack_n: ack_n, paper_out_n: paper_out_n,
                    selected: selected, fault_n: fault_n};

    prt_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .STEP(STEP)) u_dec (
        .addr (io_addr),
        .sel  (sel)
    );

    prt_wrregs #(.DW(BYTE_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_act (!wr_n),
        .sel    (sel),
        .wdata  (din[BYTE_W-1:0]),
        .data_q (prn_data),
        .ctl_q  (ctl_q)
    );

    prt_rdmux #(.BW(BW), .DW(BYTE_W)) u_rd (
        .rd_act (!rd_n),
        .sel    (sel),
        .data_q (prn_data),
        .ctl_q  (ctl_q),
        .stat   (stat),
        .rdata  (dout),
        .drive  (dout_oe)
    );

    assign strobe_n = ctl_q.strobe_n;
    assign autofd_n = ctl_q.autofd_n;
    assign init_n   = ctl_q.init_n;
    assign selin_n  = ctl_q.selin_n;
    assign irq_en   = ctl_q.irq_en;
    assign bidir    = ctl_q.bidir;

endmodule

// File: rtl/prt_regbank_chk.sv
module prt_regbank_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned BW     = 16,
    parameter int unsigned BASE   = 32'h38,
    parameter int unsigned STEP   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              wr_n,
    input logic              rd_n,
    input logic [BW-1:0]     din,
    input logic [BW-1:0]     dout,
    input logic              dout_oe,
    input logic              busy,
    input logic              ack_n,
    input logic              paper_out_n,
    input logic              selected,
    input logic              fault_n,
    input logic [7:0]        prn_data,
    input logic              strobe_n,
    input logic              autofd_n,
    input logic              init_n,
    input logic              selin_n,
    input logic              irq_en,
    input logic              bidir
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE + STEP);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE + 2 * STEP);

    logic [5:0] ctl_now;
    logic       unused_chk;
    assign ctl_now    = {bidir, irq_en, selin_n, init_n, autofd_n, strobe_n};
    assign unused_chk = ^din[BW-1:6];

    a_r1_reset_vals: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (prn_data == 8'h00 && ctl_now == 6'h0F));

    a_r2_data_load: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!wr_n && io_addr == A_DATA)) |-> prn_data == $past(din[7:0]));

    a_r3_ctl_load: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!wr_n && io_addr == A_CTRL)) |-> ctl_now == $past(din[5:0]));

    a_r4_status_read: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && io_addr == A_STAT) |->
            dout == {8'h00, busy, ack_n, paper_out_n, selected, fault_n, 3'b000});

    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
        dout[BW-1:8] == '0);

    a_r6_oe_needs_read: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> (!rd_n && (io_addr == A_DATA || io_addr == A_STAT || io_addr == A_CTRL)));

    a_r6_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> dout == '0);

    a_r7_other_addr: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!wr_n && io_addr != A_DATA && io_addr != A_CTRL))
            |-> ($stable(prn_data) && $stable(ctl_now)));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_n)) |-> ($stable(prn_data) && $stable(ctl_now)));

endmodule

bind prt_regbank prt_regbank_chk #(.ADDR_W(ADDR_W), .BW(BW), .BASE(BASE), .STEP(STEP)) u_chk (
    .clk(clk), .rst(rst), .io_addr(io_addr), .wr_n(wr_n), .rd_n(rd_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .busy(busy), .ack_n(ack_n),
    .paper_out_n(paper_out_n), .selected(selected), .fault_n(fault_n),
    .prn_data(prn_data), .strobe_n(strobe_n), .autofd_n(autofd_n), .init_n(init_n),
    .selin_n(selin_n), .irq_en(irq_en), .bidir(bidir)
);

// File: tb/test_prt_regbank.sv
`timescale 1ns/1ps
module test_prt_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  io_addr = 8'h00;
    logic        wr_n = 1'b1, rd_n = 1'b1;
    logic [15:0] din = 16'h0000;
    logic [15:0] dout;
    logic        dout_oe;
    logic        busy = 1'b0, ack_n = 1'b0, paper_out_n = 1'b0, selected = 1'b0, fault_n = 1'b0;
    logic [7:0]  prn_data;
    logic        strobe_n, autofd_n, init_n, selin_n, irq_en, bidir;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prt_regbank i_prt_regbank (
        .clk(clk), .rst(rst), .io_addr(io_addr), .wr_n(wr_n), .rd_n(rd_n), .din(din),
        .dout(dout), .dout_oe(dout_oe), .busy(busy), .ack_n(ack_n),
        .paper_out_n(paper_out_n), .selected(selected), .fault_n(fault_n),
        .prn_data(prn_data), .strobe_n(strobe_n), .autofd_n(autofd_n), .init_n(init_n),
        .selin_n(selin_n), .irq_en(irq_en), .bidir(bidir)
    );

    // vector: op(2) 0 idle 1 write 2 read | addr(8) | din(16) | status(5) | exp dout(16) | exp oe(1)
    localparam int NV = 18;
    localparam logic [47:0] VEC [NV] = '{
        {2'd2, 8'h38, 16'h0000, 5'h00, 16'h0000, 1'b1},  // R5 data reads 00 after reset
        {2'd2, 8'h3C, 16'h0000, 5'h00, 16'h000F, 1'b1},  // R5 control reads 0F after reset
        {2'd1, 8'h38, 16'hA5C3, 5'h00, 16'h0000, 1'b0},  // R2 write data, upper byte ignored
        {2'd2, 8'h38, 16'h0000, 5'h00, 16'h00C3, 1'b1},  // R2 R5
        {2'd1, 8'h3C, 16'hFFF0, 5'h00, 16'h0000, 1'b0},  // R3 write control
        {2'd2, 8'h3C, 16'h0000, 5'h00, 16'h0030, 1'b1},  // R3 bits 7..6 read 0
        {2'd1, 8'h39, 16'h003C, 5'h00, 16'h0000, 1'b0},  // R7 odd neighbour write
        {2'd2, 8'h38, 16'h0000, 5'h00, 16'h00C3, 1'b1},  // R7 data unchanged
        {2'd1, 8'h3A, 16'h00CF, 5'h00, 16'h0000, 1'b0},  // R7 write to status address
        {2'd2, 8'h3C, 16'h0000, 5'h00, 16'h0030, 1'b1},  // R7 control unchanged
        {2'd2, 8'h3A, 16'h0000, 5'h15, 16'h00A8, 1'b1},  // R4 pattern 10101
        {2'd2, 8'h3A, 16'h0000, 5'h0A, 16'h0050, 1'b1},  // R4 pattern 01010
        {2'd2, 8'h3B, 16'h0000, 5'h1F, 16'h0000, 1'b0},  // R6 odd address not decoded
        {2'd0, 8'h38, 16'h0000, 5'h1F, 16'h0000, 1'b0},  // R6 no read strobe
        {2'd1, 8'h3D, 16'h000F, 5'h00, 16'h0000, 1'b0},  // R7 odd above control
        {2'd2, 8'h3C, 16'h0000, 5'h00, 16'h0030, 1'b1},  // R7 control unchanged
        {2'd1, 8'h3C, 16'h772A, 5'h00, 16'h0000, 1'b0},  // R3 write control 2A
        {2'd2, 8'h3C, 16'h0000, 5'h00, 16'h002A, 1'b1}   // R3 R5 readback
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_ctl(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {bidir, irq_en, selin_n, init_n, autofd_n, strobe_n};
        check(act == exp, req, {10'd0, act}, {10'd0, exp});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state at the ports
        check(prn_data == 8'h00, "R1 data", {8'd0, prn_data}, 16'h0000);
        check_ctl("R1 control", 6'h0F);
        check(dout_oe == 1'b0, "R6 idle oe", {15'd0, dout_oe}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [47:0] v;
            v = VEC[i];
            @(negedge clk);
            io_addr = v[45:38];
            din     = v[37:22];
            {busy, ack_n, paper_out_n, selected, fault_n} = v[21:17];
            wr_n    = (v[47:46] != 2'd1);
            rd_n    = (v[47:46] != 2'd2);
            #1;
            if (v[47:46] != 2'd1) begin
                check(dout == v[16:1], $sformatf("vector %0d dout", i), dout, v[16:1]);
                check(dout_oe == v[0], $sformatf("R6 vector %0d oe", i),
                      {15'd0, dout_oe}, {15'd0, v[0]});
            end
        end
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1;
        #1;
        // R2 R3 port values after the table
        check(prn_data == 8'hC3, "R2 prn_data", {8'd0, prn_data}, 16'h00C3);
        check_ctl("R3 control pins", 6'h2A);

        // R8 hold with write strobe high while address and data change
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            io_addr = (k[0]) ? 8'h38 : 8'h3C;
            din = 16'hFFFF;
        end
        @(negedge clk);
        #1;
        check(prn_data == 8'hC3, "R8 data held", {8'd0, prn_data}, 16'h00C3);
        check_ctl("R8 control held", 6'h2A);

        // R2 second data pattern, all ones in the low byte
        @(negedge clk);
        io_addr = 8'h38; din = 16'h00FF; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        #1;
        check(prn_data == 8'hFF, "R2 data FF", {8'd0, prn_data}, 16'h00FF);

        // R1 reset during operation
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(prn_data == 8'h00, "R1 data after rerset", {8'd0, prn_data}, 16'h0000);
        check_ctl("R1 control after reset", 6'h0F);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule